// File: doc/BRIEF.md
# Lane Character Error Monitor

This block sits after the 8b/10b decoder of one serial receive lane. For each decoded character the decoder supplies a valid strobe and a running-disparity error flag. It also supplies a flag for a code that is not in the decoding table, a control-character (K) flag and the decoded byte. The monitor sorts these characters into three error classes and keeps one saturating counter per class. Counting runs only in the lane phases where errors are meaningful.

An optional qualification mode hides a disparity error that lands on the same character as a not-in-table error. The decoder cannot compute a valid disparity for a code it could not decode. A disparity error on any later character is still counted. An interrupt line reports any class that has a nonzero count and is enabled in a mask. When resynchronization is enabled, any counted error raises a sync request that stays high until the lane falls back to code-group synchronization.

Top module: `lane_err_monitor`

## Requirements
- R1: After reset, all three counters read 0, and `syncReq` and `errIrq` are 0.
- R2: Phase encoding is 00 = code-group sync, 01 = initial alignment, 10 = data, 11 = idle. In phase 01 or 10, a valid character with `dispErr` set raises `dispCnt` by 1 on the next clock edge, provided it is not masked by R5.
- R3: In phase 01 or 10, a valid character with `nitErr` set raises `nitCnt` by 1 on the next clock edge.
- R4: In phase 10 only, a valid character with `isK` set, `nitErr` clear and a byte other than 0x7C or 0xFC raises `kCnt` by 1. A K character in phase 01, or one carrying 0x7C or 0xFC, does not.
- R5: With `qualEn` set, a disparity error on a character that also has `nitErr` set is not counted. Disparity errors on the following characters are counted. Three such characters followed by one character with only a disparity error leave `dispCnt` at 1 and `nitCnt` at 3.
- R6: With `qualEn` clear, a disparity error on a not-in-table character is counted.
- R7: Characters in phase 00 or 11, and characters with `chValid` low, change no counter.
- R8: Each counter stops at its all-ones value (255 by default) and stays there while further errors arrive.
- R9: `clrCnt` bit 0 clears `dispCnt`, bit 1 clears `nitCnt` and bit 2 clears `kCnt`. The counter reads 0 after the edge, and the clear wins over an increment in the same cycle.
- R10: `errIrq` is high exactly when some class i has `irqMask` bit i set and a nonzero counter. The bit order is the same as in R9.
- R11: With `resyncEn` set, any counted error raises `syncReq` from the next edge. It stays high through clean characters and drops on the edge after phase 00 is seen.
- R12: With `resyncEn` clear, errors never raise `syncReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chValid | input | 1 | Decoded character present this cycle |
| dispErr | input | 1 | Running-disparity error on this character |
| nitErr | input | 1 | Code not found in the decoding table |
| isK | input | 1 | Character decoded as a control character |
| chData | input | 8 | Decoded byte |
| phase | input | 2 | Lane phase: 00 sync, 01 alignment, 10 data, 11 idle |
| qualEn | input | 1 | Mask disparity errors on not-in-table characters |
| resyncEn | input | 1 | Let counted errors raise the sync request |
| irqMask | input | 3 | Per-class interrupt enable |
| clrCnt | input | 3 | Per-class counter clear, write-one pulse |
| dispCnt | output | 8 | Disparity error count |
| nitCnt | output | 8 | Not-in-table error count |
| kCnt | output | 8 | Unexpected control character count |
| errIrq | output | 1 | Error interrupt |
| syncReq | output | 1 | Resynchronization request |

## Verification
On every cycle, the assertions check several properties:
- counters change by at most one step, hold at their ceiling and go to zero after a clear;
- nothing is counted during code-group sync;
- a qualified disparity error on a not-in-table character leaves the disparity count alone;
- a disallowed K character in the data phase is counted;
- the sync request obeys its enable and its release in sync phase.

Only the bench scenarios can show the exact count after a given error sequence. Examples are the three-not-in-table case, the alignment K bytes that are allowed, the mapping from mask bits to interrupt and the full hold-and-release life of a sync request.

// File: rtl/lem_pkg.sv
package lem_pkg;
  localparam int NUM_CLS  = 3;
  localparam int CLS_DISP = 0;
  localparam int CLS_NIT  = 1;
  localparam int CLS_KCH  = 2;

  typedef enum logic [1:0] {
    PH_CGS  = 2'b00,
    PH_ILAS = 2'b01,
    PH_DATA = 2'b10,
    PH_IDLE = 2'b11
  } lanePhase_e;

  typedef struct packed {
    logic [NUM_CLS-1:0] inc;
    logic [NUM_CLS-1:0] clr;
  } cntStrobe_t;
endpackage

// File: rtl/lem_ctrl.sv
module lem_ctrl
  import lem_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ALIGN_FRAME  = 8'h7C,
  parameter logic [DATA_W-1:0] ALIGN_MFRAME = 8'hFC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chValid,
  input  logic               dispErr,
  input  logic               nitErr,
  input  logic               isK,
  input  logic [DATA_W-1:0]  chData,
  input  logic [1:0]         phase,
  input  logic               qualEn,
  input  logic               resyncEn,
  input  logic [NUM_CLS-1:0] clrCnt,
  output cntStrobe_t         strobe,
  output logic               syncReq
);
  lanePhase_e ph;
  logic live, alignK, evDisp, evNit, evK;

  assign ph = lanePhase_e'(phase);

  always_comb begin
    live   = chValid && (ph == PH_ILAS || ph == PH_DATA);
    alignK = (chData == ALIGN_FRAME) || (chData == ALIGN_MFRAME);
    // qualification hides only the disparity flag of the bad-code slot itself
    evDisp = live && dispErr && !(qualEn && nitErr);
    evNit  = live && nitErr;
    evK    = live && (ph == PH_DATA) && isK && !nitErr && !alignK;
    strobe.inc = '0;
    strobe.inc[CLS_DISP] = evDisp;
    strobe.inc[CLS_NIT]  = evNit;
    strobe.inc[CLS_KCH]  = evK;
    strobe.clr = clrCnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      syncReq <= 1'b0;
    else if (ph == PH_CGS)
      syncReq <= 1'b0;
    else if (resyncEn && (|strobe.inc))
      syncReq <= 1'b1;
  end
endmodule

// File: rtl/lem_counters.sv
module lem_counters
  import lem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  cntStrobe_t                 strobe,
  output logic [NUM_CLS*CNT_W-1:0]   cntFlat,
  output logic [NUM_CLS-1:0]         cntNonZero
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt <= '0;
      else if (strobe.clr[g])
        cnt <= '0;
      else if (strobe.inc[g] && cnt != CNT_MAX)
        cnt <= cnt + CNT_ONE;
    end
    assign cntFlat[g*CNT_W +: CNT_W] = cnt;
    assign cntNonZero[g] = |cnt;
  end
endmodule

// File: rtl/lane_err_monitor.sv
module lane_err_monitor
  import lem_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chValid,
  input  logic               dispErr,
  input  logic               nitErr,
  input  logic               isK,
  input  logic [DATA_W-1:0]  chData,
  input  logic [1:0]         phase,
  input  logic               qualEn,
  input  logic               resyncEn,
  input  logic [2:0]         irqMask,
  input  logic [2:0]         clrCnt,
  output logic [CNT_W-1:0]   dispCnt,
  output logic [CNT_W-1:0]   nitCnt,
  output logic [CNT_W-1:0]   kCnt,
  output logic               errIrq,
  output logic               syncReq
);
  cntStrobe_t                 strobe;
  logic [NUM_CLS*CNT_W-1:0]   cntFlat;
  logic [NUM_CLS-1:0]         cntNonZero;

  lem_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chValid(chValid), .dispErr(dispErr),
    .nitErr(nitErr), .isK(isK), .chData(chData), .phase(phase),
    .qualEn(qualEn), .resyncEn(resyncEn), .clrCnt(clrCnt),
    .strobe(strobe), .syncReq(syncReq)
  );

  lem_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .cntFlat(cntFlat), .cntNonZero(cntNonZero)
  );

  assign dispCnt = cntFlat[CLS_DISP*CNT_W +: CNT_W];
  assign nitCnt  = cntFlat[CLS_NIT*CNT_W +: CNT_W];
  assign kCnt    = cntFlat[CLS_KCH*CNT_W +: CNT_W];
  assign errIrq  = |(irqMask & cntNonZero);
endmodule

// File: rtl/lem_checker.sv
module lem_checker #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chValid,
  input logic              dispErr,
  input logic              nitErr,
  input logic              isK,
  input logic [DATA_W-1:0] chData,
  input logic [1:0]        phase,
  input logic              qualEn,
  input logic              resyncEn,
  input logic [2:0]        irqMask,
  input logic [2:0]        clrCnt,
  input logic [CNT_W-1:0]  dispCnt,
  input logic [CNT_W-1:0]  nitCnt,
  input logic [CNT_W-1:0]  kCnt,
  input logic              errIrq,
  input logic              syncReq
);
  localparam logic [CNT_W-1:0] TOP = '1;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_cgs_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && clrCnt == 3'b000) |=> ($stable(dispCnt) && $stable(nitCnt) && $stable(kCnt)));

  assert_qual_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chValid && qualEn && nitErr && dispErr && !clrCnt[0]) |=> $stable(dispCnt));

  assert_unexp_k_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chValid && phase == 2'b10 && isK && !nitErr && chData != 8'h7C && chData != 8'hFC
     && !clrCnt[2] && kCnt != TOP) |=> (kCnt == $past(kCnt) + ONE));

  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dispCnt == TOP && !clrCnt[0]) |=> (dispCnt == TOP));

  assert_one_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clrCnt[0] |=> (dispCnt == $past(dispCnt) || dispCnt == $past(dispCnt) + ONE));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clrCnt[1] |=> (nitCnt == '0));

  assert_sync_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00) |=> !syncReq);

  assert_sync_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!resyncEn && !syncReq) |=> !syncReq);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irqMask == 3'b000) |-> !errIrq);
endmodule

bind lane_err_monitor lem_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chValid(chValid), .dispErr(dispErr),
  .nitErr(nitErr), .isK(isK), .chData(chData), .phase(phase),
  .qualEn(qualEn), .resyncEn(resyncEn), .irqMask(irqMask), .clrCnt(clrCnt),
  .dispCnt(dispCnt), .nitCnt(nitCnt), .kCnt(kCnt), .errIrq(errIrq),
  .syncReq(syncReq)
);

// File: tb/lane_err_monitor_bench.sv
`timescale 1ns/1ps
module lane_err_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chValid = 1'b0, dispErr = 1'b0, nitErr = 1'b0, isK = 1'b0;
  logic [7:0] chData = 8'h00;
  logic [1:0] phase = 2'b00;
  logic       qualEn = 1'b0, resyncEn = 1'b0;
  logic [2:0] irqMask = 3'b000, clrCnt = 3'b000;
  logic [7:0] dispCnt, nitCnt, kCnt;
  logic       errIrq, syncReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lane_err_monitor u_lane_err_monitor (
    .clk(clk), .rst_n(rst_n), .chValid(chValid), .dispErr(dispErr),
    .nitErr(nitErr), .isK(isK), .chData(chData), .phase(phase),
    .qualEn(qualEn), .resyncEn(resyncEn), .irqMask(irqMask), .clrCnt(clrCnt),
    .dispCnt(dispCnt), .nitCnt(nitCnt), .kCnt(kCnt), .errIrq(errIrq),
    .syncReq(syncReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one character for one clock edge; returns at the next falling edge
  task automatic sendChar(input logic [1:0] ph, input logic d, input logic n,
                          input logic k, input logic [7:0] b);
    phase = ph; chValid = 1'b1; dispErr = d; nitErr = n; isK = k; chData = b;
    @(negedge clk);
    chValid = 1'b0; dispErr = 1'b0; nitErr = 1'b0; isK = 1'b0; chData = 8'h00;
  endtask

  task automatic clearAll();
    clrCnt = 3'b111;
    @(negedge clk);
    clrCnt = 3'b000;
  endtask

  task automatic t_reset();
    check("R1 dispCnt", dispCnt, 0);
    check("R1 nitCnt", nitCnt, 0);
    check("R1 kCnt", kCnt, 0);
    check("R1 syncReq", syncReq, 0);
    check("R1 errIrq", errIrq, 0);
  endtask

  task automatic t_disp();
    clearAll();
    sendChar(2'b01, 1, 0, 0, 8'h1C);
    sendChar(2'b10, 1, 0, 0, 8'h55);
    check("R2 dispCnt", dispCnt, 2);
  endtask

  task automatic t_nit();
    clearAll();
    sendChar(2'b01, 0, 1, 0, 8'h00);
    sendChar(2'b10, 0, 1, 0, 8'h00);
    sendChar(2'b10, 0, 1, 0, 8'h00);
    check("R3 nitCnt", nitCnt, 3);
    check("R3 dispCnt untouched", dispCnt, 0);
  endtask

  task automatic t_unexpK();
    clearAll();
    sendChar(2'b10, 0, 0, 1, 8'hBC);
    sendChar(2'b10, 0, 0, 1, 8'h7C);
    sendChar(2'b10, 0, 0, 1, 8'hFC);
    sendChar(2'b01, 0, 0, 1, 8'h1C);
    sendChar(2'b10, 0, 0, 0, 8'hBC);
    check("R4 kCnt", kCnt, 1);
  endtask

  task automatic t_qual();
    clearAll();
    qualEn = 1'b1;
    for (int i = 0; i < 3; i++) sendChar(2'b10, 1, 1, 0, 8'h00);
    check("R5 dispCnt masked", dispCnt, 0);
    sendChar(2'b10, 1, 0, 0, 8'h33);
    check("R5 dispCnt after", dispCnt, 1);
    check("R5 nitCnt", nitCnt, 3);
    qualEn = 1'b0;
  endtask

  task automatic t_noQual();
    clearAll();
    sendChar(2'b10, 1, 1, 0, 8'h00);
    check("R6 dispCnt", dispCnt, 1);
  endtask

  task automatic t_ignore();
    clearAll();
    sendChar(2'b00, 1, 1, 1, 8'hBC);
    sendChar(2'b11, 1, 1, 1, 8'hBC);
    phase = 2'b10; dispErr = 1'b1; nitErr = 1'b1; isK = 1'b1; chData = 8'h11;
    @(negedge clk);
    dispErr = 1'b0; nitErr = 1'b0; isK = 1'b0;
    check("R7 dispCnt", dispCnt, 0);
    check("R7 nitCnt", nitCnt, 0);
    check("R7 kCnt", kCnt, 0);
  endtask

  task automatic t_sat();
    clearAll();
    for (int i = 0; i < 260; i++) sendChar(2'b10, 1, 0, 0, 8'h00);
    check("R8 dispCnt saturated", dispCnt, 255);
  endtask

  task automatic t_clear();
    sendChar(2'b10, 0, 1, 0, 8'h00);
    clrCnt = 3'b001;
    sendChar(2'b10, 1, 1, 0, 8'h00);
    clrCnt = 3'b000;
    check("R9 dispCnt cleared over inc", dispCnt, 0);
    check("R9 nitCnt kept", nitCnt, 2);
    clrCnt = 3'b010;
    @(negedge clk);
    clrCnt = 3'b000;
    check("R9 nitCnt cleared", nitCnt, 0);
  endtask

  task automatic t_irq();
    clearAll();
    irqMask = 3'b100;
    sendChar(2'b10, 1, 0, 0, 8'h00);
    check("R10 irq masked class", errIrq, 0);
    sendChar(2'b10, 0, 0, 1, 8'h3C);
    check("R10 irq K class", errIrq, 1);
    irqMask = 3'b001;
    clrCnt = 3'b001;
    @(negedge clk);
    clrCnt = 3'b000;
    check("R10 irq after clear", errIrq, 0);
    irqMask = 3'b000;
  endtask

  task automatic t_resync();
    clearAll();
    resyncEn = 1'b1;
    sendChar(2'b10, 0, 1, 0, 8'h00);
    check("R11 syncReq raised", syncReq, 1);
    sendChar(2'b10, 0, 0, 0, 8'h12);
    sendChar(2'b01, 0, 0, 0, 8'h12);
    check("R11 syncReq held", syncReq, 1);
    phase = 2'b00;
    @(negedge clk);
    check("R11 syncReq released", syncReq, 0);
    resyncEn = 1'b0;
  endtask

  task automatic t_noResync();
    resyncEn = 1'b0;
    sendChar(2'b10, 1, 1, 1, 8'h01);
    sendChar(2'b10, 0, 0, 1, 8'h02);
    check("R12 syncReq stays low", syncReq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disp();
    t_nit();
    t_unexpK();
    t_qual();
    t_noQual();
    t_ignore();
    t_sat();
    t_clear();
    t_irq();
    t_resync();
    t_noResync();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule